// File: doc/BRIEF.md
# Serial Flash Read Command Front-End

This block is the slave side of a serial flash read path. It watches the chip-select, serial clock and serial data-in pins, collects an 8-bit command code and a 24-bit start address, then waits out the number of filler bytes that the command calls for. After that it streams memory bytes out on the serial data-out pin until chip-select goes high. All bits move most significant bit first. Only five read command codes are recognised. The filler count is 4 bytes for E8h, 2 for 1Bh, 1 for 0Bh, and none for 03h or 01h. Any other code makes the block stay silent until the transaction ends.

The pins are sampled by the block's own clock through a synchroniser. The serial clock must therefore stay high and stay low for at least eight system-clock cycles each. Bytes come from a memory model through a simple request port. A request carries the address, and the byte returns on `mem_data` in the following clock cycle. A separate counter holds the address. It is loaded from the received address and advanced once per request, and it wraps at 2^ADDR_W. The block fetches one byte ahead of the byte being shifted out, so crossing a page or the end of the array adds no gap.

The state machine has these states and transitions:
- IDLE moves to OPCODE on a chip-select falling edge.
- OPCODE moves to ADDRESS after eight bits when the code is known, and to IGNORE when it is not.
- ADDRESS moves to PREFETCH after 24 bits.
- PREFETCH moves to DUMMY when filler bytes are due, and to STREAM when none are.
- DUMMY moves to STREAM after its last filler bit.
- Chip-select high forces every state back to IDLE.

Top module: `flash_read_frontend`

## Requirements
- R1: After reset, and whenever chip-select is high, `spi_miso_oe` is 0, `spi_miso` is 0 and `mem_req` stays low.
- R2: A transaction starts only on a falling edge of chip-select, and the first eight bits sampled on rising serial-clock edges form the command code, most significant bit first.
- R3: The next 24 bits, most significant bit first, form the start address; only its low ADDR_W bits are used.
- R4: The number of filler bytes skipped before data is 4 for code E8h, 2 for 1Bh, 1 for 0Bh and 0 for 03h and 01h.
- R5: The first data bit appears on the falling serial-clock edge after the last rising edge of the address or filler bytes. `spi_miso_oe` is 0 before that edge and 1 from it on. `spi_miso` changes only after falling edges, and each byte goes out most significant bit first.
- R6: Successive bytes come from consecutive addresses, wrapping from 2^ADDR_W-1 to 0 without a gap.
- R7: Any other command code keeps `spi_miso_oe` low and issues no memory request until chip-select rises; the next transaction then works normally.
- R8: A rising edge of chip-select ends a read at any bit position and releases `spi_miso_oe`; a following transaction decodes from a clean start.
- R9: Serial-clock and data-in activity while chip-select is high causes no request or output and does not disturb the next command.
- R10: The first memory request of a read carries the start address, and each later request carries the previous address plus one modulo 2^ADDR_W; the returned byte is taken the cycle after `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; 0 means high-impedance |
| mem_req | output | 1 | One-cycle byte read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_data | input | 8 | Byte returned the cycle after `mem_req` |

## Verification
Every recognised code is driven with random addresses and random filler bits. Because the filler content is random, a wrong filler count for a code shows up at once as shifted or misaligned data bytes. Addresses near the top of the range separate correct wrapping from carry into unused bits. A read cut off mid-byte followed by a fresh read shows whether chip-select really resets the bit position. An unknown code, and clock noise sent while deselected, confirm that nothing is driven or requested in those cases and that the decoder starts clean afterwards.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDRESS,
        ST_PREFETCH,
        ST_DUMMY,
        ST_STREAM,
        ST_IGNORE
    } fr_state_e;

    localparam int OPC_BITS        = 8;
    localparam int ADDR_BYTES      = 3;
    localparam int ADDR_BITS       = ADDR_BYTES * 8;
    localparam int MAX_DUMMY_BYTES = 4;
    localparam int MAX_PHASE_BITS  = (MAX_DUMMY_BYTES * 8 > ADDR_BITS) ? MAX_DUMMY_BYTES * 8 : ADDR_BITS;
    localparam int CNT_W           = $clog2(MAX_PHASE_BITS);
    localparam int DUMMY_W         = $clog2(MAX_DUMMY_BYTES + 1);

    localparam logic [7:0] CMD_RD_DUMMY4 = 8'hE8;
    localparam logic [7:0] CMD_RD_DUMMY2 = 8'h1B;
    localparam logic [7:0] CMD_RD_DUMMY1 = 8'h0B;
    localparam logic [7:0] CMD_RD_SLOW   = 8'h03;
    localparam logic [7:0] CMD_RD_LOWPWR = 8'h01;

    typedef struct packed {
        logic               known;
        logic [DUMMY_W-1:0] dummy_bytes;
    } fr_decode_t;

    function automatic fr_decode_t fr_decode(input logic [7:0] code);
        fr_decode_t d;
        d.known       = 1'b1;
        d.dummy_bytes = '0;
        case (code)
            CMD_RD_DUMMY4: d.dummy_bytes = DUMMY_W'(4);
            CMD_RD_DUMMY2: d.dummy_bytes = DUMMY_W'(2);
            CMD_RD_DUMMY1: d.dummy_bytes = DUMMY_W'(1);
            CMD_RD_SLOW:   d.dummy_bytes = '0;
            CMD_RD_LOWPWR: d.dummy_bytes = '0;
            default:       d.known       = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fr_pin_sync.sv
module fr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic si_pin,
    output logic cs_n_s,
    output logic si_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall
);

    logic [STAGES-1:0] cs_chain;
    logic [STAGES-1:0] sck_chain;
    logic [STAGES-1:0] si_chain;
    logic              sck_q;
    logic              cs_q;
    logic              sck_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_chain  <= '1;
            sck_chain <= '0;
            si_chain  <= '0;
            sck_q     <= 1'b0;
            cs_q      <= 1'b1;
        end else begin
            cs_chain  <= {cs_chain[STAGES-2:0], cs_n_pin};
            sck_chain <= {sck_chain[STAGES-2:0], sck_pin};
            si_chain  <= {si_chain[STAGES-2:0], si_pin};
            sck_q     <= sck_chain[STAGES-1];
            cs_q      <= cs_chain[STAGES-1];
        end
    end

    assign cs_n_s   = cs_chain[STAGES-1];
    assign sck_s    = sck_chain[STAGES-1];
    assign si_s     = si_chain[STAGES-1];
    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign cs_fall  = ~cs_n_s & cs_q;

endmodule

// File: rtl/fr_addr_ctr.sv
module fr_addr_ctr #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/fr_tx_shift.sv
module fr_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              cap,
    input  logic [BYTE_W-1:0] cap_data,
    output logic              so,
    output logic              so_oe,
    output logic              fetch_next
);

    localparam int IDX_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] buf_q;
    logic [BYTE_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;
    logic              oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            sh_q  <= '0;
            idx_q <= '0;
            oe_q  <= 1'b0;
        end else begin
            if (cap) begin
                buf_q <= cap_data;
            end
            if (clear) begin
                sh_q  <= '0;
                idx_q <= '0;
                oe_q  <= 1'b0;
            end else if (shift_en) begin
                oe_q  <= 1'b1;
                idx_q <= idx_q + IDX_W'(1);
                if (idx_q == '0) begin
                    sh_q <= buf_q;
                end else begin
                    sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign fetch_next = shift_en && !clear && (idx_q == '0);
    assign so         = oe_q & sh_q[BYTE_W-1];
    assign so_oe      = oe_q;

endmodule

// File: rtl/flash_read_frontend.sv
module flash_read_frontend #(
    parameter int ADDR_W      = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data
);

    import fr_pkg::*;

    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(OPC_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);

    logic               cs_n_s;
    logic               si_s;
    logic               sck_rise;
    logic               sck_fall;
    logic               cs_fall;

    fr_state_e          state_q, state_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic [ADDR_W-1:0]  rx_q, rx_n;
    logic [DUMMY_W-1:0] dummy_q, dummy_n;
    logic               req_q;

    logic [ADDR_W-1:0]  rx_shifted;
    fr_decode_t         dec;
    logic [CNT_W-1:0]   dummy_last;

    logic               load_addr;
    logic               tx_clear;
    logic               tx_shift;
    logic               fetch_next;

    fr_pin_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_pin (spi_cs_n),
        .sck_pin  (spi_sck),
        .si_pin   (spi_mosi),
        .cs_n_s   (cs_n_s),
        .si_s     (si_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_fall  (cs_fall)
    );

    assign rx_shifted = ADDR_W'({rx_q, si_s});
    assign dec        = fr_decode(rx_shifted[7:0]);
    assign dummy_last = CNT_W'(({3'b000, dummy_q} << 3) - 1);

    // next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        rx_n    = rx_q;
        dummy_n = dummy_q;
        if (cs_n_s) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall) begin
                        state_n = ST_OPCODE;
                        cnt_n   = '0;
                    end
                end
                ST_OPCODE: begin
                    if (sck_rise) begin
                        rx_n  = rx_shifted;
                        cnt_n = cnt_q + CNT_W'(1);
                        if (cnt_q == OPC_LAST) begin
                            cnt_n = '0;
                            if (dec.known) begin
                                state_n = ST_ADDRESS;
                                dummy_n = dec.dummy_bytes;
                            end else begin
                                state_n = ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ADDRESS: begin
                    if (sck_rise) begin
                        rx_n  = rx_shifted;
                        cnt_n = cnt_q + CNT_W'(1);
                        if (cnt_q == ADDR_LAST) begin
                            cnt_n   = '0;
                            state_n = ST_PREFETCH;
                        end
                    end
                end
                ST_PREFETCH: begin
                    state_n = (dummy_q == '0) ? ST_STREAM : ST_DUMMY;
                end
                ST_DUMMY: begin
                    if (sck_rise) begin
                        cnt_n = cnt_q + CNT_W'(1);
                        if (cnt_q == dummy_last) begin
                            cnt_n   = '0;
                            state_n = ST_STREAM;
                        end
                    end
                end
                ST_STREAM: state_n = ST_STREAM;
                ST_IGNORE: state_n = ST_IGNORE;
                default:   state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rx_q    <= '0;
            dummy_q <= '0;
            req_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            rx_q    <= rx_n;
            dummy_q <= dummy_n;
            req_q   <= mem_req;
        end
    end

    // outputs
    always_comb begin
        load_addr = !cs_n_s && (state_q == ST_ADDRESS) && sck_rise && (cnt_q == ADDR_LAST);
        tx_clear  = cs_n_s || (state_q != ST_STREAM);
        tx_shift  = !cs_n_s && (state_q == ST_STREAM) && sck_fall;
        mem_req   = (!cs_n_s && (state_q == ST_PREFETCH)) || fetch_next;
    end

    fr_addr_ctr #(
        .ADDR_W(ADDR_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_addr),
        .load_val (rx_shifted),
        .step     (mem_req),
        .addr     (mem_addr)
    );

    fr_tx_shift #(
        .BYTE_W(8)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (tx_clear),
        .shift_en   (tx_shift),
        .cap        (req_q),
        .cap_data   (mem_data),
        .so         (spi_miso),
        .so_oe      (spi_miso_oe),
        .fetch_next (fetch_next)
    );

endmodule

// File: rtl/fr_checker.sv
module fr_checker (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n_s,
    input fr_pkg::fr_state_e  state,
    input logic               mem_req,
    input logic               so,
    input logic               so_oe
);

    import fr_pkg::*;

    AST_SO_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe |-> !so);                                                 // R1
    AST_DESELECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !so_oe);                                              // R8
    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (state == ST_IDLE));                                  // R8
    AST_DRIVE_ONLY_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (state == ST_STREAM));                                 // R5
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!mem_req && !so_oe));                  // R7
    AST_REQ_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((state == ST_PREFETCH) || (state == ST_STREAM)));    // R10
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);                                           // R10

endmodule

bind flash_read_frontend fr_checker u_fr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_s  (cs_n_s),
    .state   (state_q),
    .mem_req (mem_req),
    .so      (spi_miso),
    .so_oe   (spi_miso_oe)
);

// File: tb/tb_flash_read_frontend.sv
module tb_flash_read_frontend;

    localparam int AW   = 19;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          spi_cs_n;
    logic          spi_sck;
    logic          spi_mosi;
    logic          spi_miso;
    logic          spi_miso_oe;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;

    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 0;
    logic [AW-1:0] rec_addr [16];
    int            rec_n    = 0;

    always #4 clk = ~clk;

    flash_read_frontend #(.ADDR_W(AW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_data    (mem_data)
    );

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        logic [31:0] x;
        x = 32'(a);
        return 8'(x[7:0] * 8'd7) ^ x[15:8] ^ x[23:16] ^ 8'hA5;
    endfunction

    function automatic int dummy_of(input logic [7:0] code);
        case (code)
            8'hE8:   return 4;
            8'h1B:   return 2;
            8'h0B:   return 1;
            default: return 0;
        endcase
    endfunction

    // memory model: byte valid the cycle after the request
    always @(posedge clk) begin
        if (mem_req) mem_data <= mem_byte(mem_addr);
    end

    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (rec_n < 16) rec_addr[rec_n] = mem_addr;
            rec_n = rec_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sck_cycle(input logic si_v, output logic so_r, output logic oe_r, output logic so_h);
        spi_mosi = si_v;
        repeat (HALF) @(negedge clk);
        so_r = spi_miso;
        oe_r = spi_miso_oe;
        spi_sck = 1'b1;
        repeat (HALF) @(negedge clk);
        so_h = spi_miso;
        spi_sck = 1'b0;
    endtask

    task automatic end_cs(input string tag);
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        chk(spi_miso_oe == 1'b0 && spi_miso == 1'b0, tag, {spi_miso_oe, spi_miso}, 0);
    endtask

    task automatic do_read(input logic [7:0] code, input logic [23:0] addr, input int nbits, input string tag);
        logic so_r, oe_r, so_h;
        bit early_oe = 0, oe_bad = 0, stab_bad = 0, seq_bad = 0;
        logic [7:0] got = '0;
        logic [AW-1:0] start, a;
        int nd;
        start = AW'(addr);
        nd = dummy_of(code);
        rec_n = 0;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            sck_cycle(code[i], so_r, oe_r, so_h);
            if (oe_r) early_oe = 1;
        end
        for (int i = 23; i >= 0; i--) begin
            sck_cycle(addr[i], so_r, oe_r, so_h);
            if (oe_r) early_oe = 1;
        end
        for (int i = 0; i < nd * 8; i++) begin
            sck_cycle(1'($urandom), so_r, oe_r, so_h);
            if (oe_r) early_oe = 1;
        end
        chk(!early_oe, "R5 output enabled before data", 32'(early_oe), 0);
        for (int n = 0; n < nbits; n++) begin
            sck_cycle(1'($urandom), so_r, oe_r, so_h);
            got = {got[6:0], so_r};
            if (!oe_r) oe_bad = 1;
            if (so_h !== so_r) stab_bad = 1;
            if (n % 8 == 7) begin
                a = start + AW'(n / 8);
                chk(got == mem_byte(a), tag, 32'(got), 32'(mem_byte(a)));
            end
        end
        if (nbits > 0) begin
            chk(!oe_bad, "R5 output enable during data", 32'(oe_bad), 0);
            chk(!stab_bad, "R5 output moved while clock high", 32'(stab_bad), 0);
        end
        end_cs("R8 release after chip-select high");
        if (nbits >= 8) begin
            chk(rec_n > 0 && rec_addr[0] == start, "R10 first request address R3", 32'(rec_addr[0]), 32'(start));
            for (int i = 1; i < rec_n && i < 16; i++)
                if (rec_addr[i] != rec_addr[i-1] + AW'(1)) seq_bad = 1;
            chk(!seq_bad, "R10 request address sequence", 32'(seq_bad), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] codes [5];
        logic so_r, oe_r, so_h;
        bit oe_seen;
        codes[0] = 8'hE8; codes[1] = 8'h1B; codes[2] = 8'h0B; codes[3] = 8'h03; codes[4] = 8'h01;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sck = 1'b0; spi_mosi = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R1: reset state
        chk(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R1 reset outputs", {spi_miso_oe, spi_miso}, 0);
        chk(rec_n == 0, "R1 no request after reset", 32'(rec_n), 0);

        // R2, R4: every code once, directed
        do_read(8'hE8, 24'h012345, 24, "R4 four filler bytes R2");
        do_read(8'h1B, 24'h000100, 24, "R4 two filler bytes");
        do_read(8'h0B, 24'h03FFFF, 24, "R4 one filler byte");
        do_read(8'h03, 24'h0000FF, 24, "R4 no filler slow code");
        do_read(8'h01, 24'h055AA5, 24, "R4 no filler low power code");

        // R6: wrap at top of the array, upper address bits set
        do_read(8'h0B, 24'hF7FFFE, 32, "R6 wrap to zero R3");

        // R8: cut off mid-byte, then a fresh read
        do_read(8'h03, 24'h001000, 11, "R8 partial");
        do_read(8'h1B, 24'h002000, 16, "R8 clean restart");

        // R7: unknown code stays silent
        rec_n = 0; oe_seen = 0;
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            sck_cycle(1'(8'h9F >> i), so_r, oe_r, so_h);
            if (oe_r) oe_seen = 1;
        end
        for (int i = 0; i < 48; i++) begin
            sck_cycle(1'($urandom), so_r, oe_r, so_h);
            if (oe_r || so_r) oe_seen = 1;
        end
        chk(!oe_seen, "R7 unknown code drives output", 32'(oe_seen), 0);
        chk(rec_n == 0, "R7 unknown code requests", 32'(rec_n), 0);
        end_cs("R7 end of ignored command");
        do_read(8'h0B, 24'h00ABCD, 16, "R7 recovery read");

        // R9: noise while deselected
        rec_n = 0; oe_seen = 0;
        for (int i = 0; i < 24; i++) begin
            sck_cycle(1'($urandom), so_r, oe_r, so_h);
            if (oe_r || so_r) oe_seen = 1;
        end
        chk(!oe_seen && rec_n == 0, "R9 activity while deselected", 32'(rec_n), 0);
        do_read(8'hE8, 24'h07FF00, 16, "R9 read after noise");

        // random mix
        for (int t = 0; t < 28; t++) begin
            logic [7:0] c;
            c = codes[$urandom % 5];
            do_read(c, 24'($urandom), 8 * (1 + int'($urandom % 4)), "R6 random read R4");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule